// File: doc/BRIEF.md
# USB Dual-Role Port State Controller

This block decides, cycle by cycle, whether a USB port behaves as the A-side host or the B-side peripheral. It watches the ID pin, the session and VBUS comparator flags, a connect indication from the host engine and three software controls (a bus-request pulse, a bus-drop level and a clear-error pulse). From these it steps through a fixed table of A-side and B-side states. It switches VBUS, the host engine and the peripheral engine on and off as states are entered, and it reports the current state as a 4-bit code.

Every input passes through a two-flop synchroniser before the state logic sees it. A wait-for-connect timer runs while the port, as A-device, powers VBUS and waits for a B-device to attach. The timer counts pulses on a tick input, one pulse per 10 ms. Its default limit of 2000 ticks gives 20 s. When the timer expires, the block drops VBUS and leaves the session. If VBUS collapses while the block is powering it, the block traps in an error state until software clears the error, bus-drop is raised or the ID pin goes high.

Top module: `otg_role_ctrl`

## Requirements
- R1: State codes are fixed: 0 undefined, 1 b_idle, 3 b_peripheral, 6 a_idle, 7 a_wait_vrise, 8 a_wait_bcon, 9 a_host, 12 a_wait_vfall, 13 a_vbus_err; no other code is ever entered. During reset the state is 0 and every output is low. The first evaluation after reset applies the b_idle rules, with the synchronised ID treated as high until the pin has passed through the two flops.
- R2: From b_idle (or undefined), ID low goes to a_idle; otherwise a valid B-session goes to b_peripheral, which raises the peripheral enable. From b_peripheral, ID low or loss of B-session returns to b_idle, which drops the peripheral enable.
- R3: From a_idle, ID high goes to b_idle. Otherwise, with bus-drop low and either the latched bus-request or SRP-detect set, the block goes to a_wait_vrise and turns VBUS on. While bus-drop is high the block stays in a_idle.
- R4: a_wait_vrise moves to a_wait_bcon once A-VBUS-valid is high. Entry into a_wait_bcon from any state other than a_host raises the host enable. Every entry into a_wait_bcon restarts the connect-wait timer.
- R5: In a_wait_bcon the exits are taken in this priority: ID high, bus-drop or timer expiry go to a_wait_vfall; otherwise loss of A-VBUS-valid goes to a_vbus_err; otherwise a connected B-device goes to a_host. Each exit stops the timer and clears its expiry flag.
- R6: The timer expires after TIMEOUT_TICKS synchronised tick pulses counted from its start (default 2000, one tick per 10 ms). Clock cycles without a tick do not advance it.
- R7: From a_host, ID high, loss of the connected flag or bus-drop returns to a_wait_bcon. Otherwise loss of A-VBUS-valid goes to a_vbus_err.
- R8: The connected flag sets on a rising edge of the synchronised connect input and clears when that input is low. Entry into a_wait_vfall clears the flag and turns VBUS off, and a connect input held high does not set the flag again. a_wait_vfall goes to a_idle on ID high, on the bus-request latch, or on the connected flag clear together with A-session-valid.
- R9: In a_vbus_err, ID high, the clear-error latch or bus-drop goes to a_wait_vfall, and that exit clears the clear-error latch. Without one of these the block stays in a_vbus_err, and VBUS stays on.
- R10: Entry into b_idle clears the default-A output. Entry into a_idle sets default-A, and drops the host enable when the previous state was a_wait_vfall. Host enable and peripheral enable are never high together.
- R11: A bus-request pulse sets the bus-request latch only while bus-drop is low. Bus-drop high clears the latch, and so does the a_wait_bcon exit of highest priority. A clear-error pulse is latched only while default-A is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| idPin | input | 1 | ID pin level, low selects the A-side |
| bSessValid | input | 1 | B-session valid comparator |
| aVbusValid | input | 1 | A-side VBUS valid comparator |
| aSessValid | input | 1 | A-session valid comparator |
| connDetect | input | 1 | Far-end device connected (level, from the host engine) |
| srpDetect | input | 1 | Session request detected |
| busDrop | input | 1 | Software bus-drop level |
| busReqPulse | input | 1 | Software bus-request, one-cycle pulse |
| clrErrPulse | input | 1 | Software clear-error, one-cycle pulse |
| tick10ms | input | 1 | Timer tick, one-cycle pulse per 10 ms |
| vbusOn | output | 1 | VBUS supply enable |
| hostEn | output | 1 | Host engine enable |
| periphEn | output | 1 | Peripheral engine enable |
| defaultA | output | 1 | Port is currently the default A-device |
| roleState | output | 4 | Current state code (R1) |

## Verification
On every cycle the assertions check that the state code stays in the legal set and that the two engine enables never overlap. They also check that the peripheral enable tracks the b_peripheral state, that VBUS is off in the idle and B-side states, and that a timer expiry never appears without a running timer. Clocked properties cover the single-step rules: bus-drop in a_wait_bcon always leads to a_wait_vfall, and a_host and a_vbus_err keep or leave their state as their exit conditions require. The multi-step behaviour needs the bench's scenarios. These include the connected flag that stays cleared after VBUS fall while the connect input is still high, the bus-request latch refused under bus-drop, a clear-error latch that does not survive into a later error, and the tick-counted timeout against a tick-free wait.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;

  typedef enum logic [3:0] {
    ST_UNDEF    = 4'd0,
    ST_B_IDLE   = 4'd1,
    ST_B_SRP    = 4'd2,
    ST_B_PERIPH = 4'd3,
    ST_B_WAITA  = 4'd4,
    ST_B_HOST   = 4'd5,
    ST_A_IDLE   = 4'd6,
    ST_A_VRISE  = 4'd7,
    ST_A_BCON   = 4'd8,
    ST_A_HOST   = 4'd9,
    ST_A_SUSP   = 4'd10,
    ST_A_PERIPH = 4'd11,
    ST_A_VFALL  = 4'd12,
    ST_A_VERR   = 4'd13
  } roleState_e;

  // synchronised inputs; idS must stay the most significant field
  typedef struct packed {
    logic idS;
    logic bSessS;
    logic aVbusS;
    logic aSessS;
    logic connS;
    logic srpS;
    logic dropS;
    logic reqS;
    logic clrS;
    logic tickS;
  } syncIn_t;

  // entry-action strobes from control to datapath
  typedef struct packed {
    logic vbusSet;
    logic vbusClr;
    logic hostSet;
    logic hostClr;
    logic periphSet;
    logic periphClr;
    logic defASet;
    logic defAClr;
    logic timerStart;
    logic timerStop;
    logic reqClr;
    logic errClr;
    logic connClr;
  } strobe_t;

endpackage

// File: rtl/otg_role_sync.sv
module otg_role_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pipe[s] <= RST_VAL;
      end else if (s == 0) begin
        pipe[s] <= din;
      end else begin
        pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/otg_role_fsm.sv
module otg_role_fsm
  import otg_role_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       idS,
  input  logic       bSessS,
  input  logic       aVbusS,
  input  logic       aSessS,
  input  logic       srpS,
  input  logic       dropS,
  input  logic       busReq,
  input  logic       clrErr,
  input  logic       bConn,
  input  logic       timedOut,
  output roleState_e state,
  output strobe_t    stb
);

  roleState_e stateD;
  strobe_t    exitStb;

  // transition table, one step per cycle
  always_comb begin
    stateD  = state;
    exitStb = '0;
    unique case (state)
      ST_UNDEF, ST_B_IDLE: begin
        if (!idS)        stateD = ST_A_IDLE;
        else if (bSessS) stateD = ST_B_PERIPH;
        else             stateD = ST_B_IDLE;
      end
      ST_B_PERIPH: if (!bSessS || !idS) stateD = ST_B_IDLE;
      ST_A_IDLE: begin
        if (idS)                             stateD = ST_B_IDLE;
        else if (!dropS && (busReq || srpS)) stateD = ST_A_VRISE;
      end
      ST_A_VRISE: if (aVbusS) stateD = ST_A_BCON;
      ST_A_BCON: begin
        if (idS || dropS || timedOut) begin
          stateD = ST_A_VFALL;
          exitStb.reqClr = 1'b1;
        end else if (!aVbusS) begin
          stateD = ST_A_VERR;
        end else if (bConn) begin
          stateD = ST_A_HOST;
        end
        exitStb.timerStop = (stateD != ST_A_BCON);
      end
      ST_A_HOST: begin
        if (idS || !bConn || dropS) stateD = ST_A_BCON;
        else if (!aVbusS)           stateD = ST_A_VERR;
      end
      ST_A_VFALL: if (idS || busReq || (!bConn && aSessS)) stateD = ST_A_IDLE;
      ST_A_VERR: begin
        if (idS || clrErr || dropS) begin
          stateD = ST_A_VFALL;
          exitStb.errClr = 1'b1;
        end
      end
      default: stateD = ST_B_IDLE;
    endcase
  end

  // entry actions
  always_comb begin
    stb = exitStb;
    if (stateD != state) begin
      unique case (stateD)
        ST_B_IDLE: begin
          stb.defAClr   = 1'b1;
          stb.periphClr = (state == ST_B_PERIPH);
        end
        ST_B_PERIPH: stb.periphSet = 1'b1;
        ST_A_IDLE: begin
          stb.defASet = 1'b1;
          stb.hostClr = (state == ST_A_VFALL);
        end
        ST_A_VRISE: stb.vbusSet = 1'b1;
        ST_A_BCON: begin
          stb.hostSet    = (state != ST_A_HOST);
          stb.timerStart = 1'b1;
        end
        ST_A_VFALL: begin
          stb.connClr = 1'b1;
          stb.vbusClr = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_UNDEF;
    else       state <= stateD;
  end

  assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    state inside {ST_UNDEF, ST_B_IDLE, ST_B_PERIPH, ST_A_IDLE, ST_A_VRISE,
                  ST_A_BCON, ST_A_HOST, ST_A_VFALL, ST_A_VERR});

  assert_bcon_drop_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_A_BCON && dropS) |=> (state == ST_A_VFALL));

  assert_host_leaves_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_A_HOST && (idS || dropS)) |=> (state == ST_A_BCON));

  assert_verr_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_A_VERR && !idS && !clrErr && !dropS) |=> (state == ST_A_VERR));

endmodule

// File: rtl/otg_role_dp.sv
module otg_role_dp
  import otg_role_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 2000
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  logic    connS,
  input  logic    dropS,
  input  logic    reqS,
  input  logic    clrS,
  input  logic    tickS,
  output logic    vbusOn,
  output logic    hostEn,
  output logic    periphEn,
  output logic    defaultA,
  output logic    busReq,
  output logic    clrErr,
  output logic    bConn,
  output logic    timedOut
);

  localparam int CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_TICKS - 1);

  logic             connPrev;
  logic             timerRun;
  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vbusOn   <= 1'b0;
      hostEn   <= 1'b0;
      periphEn <= 1'b0;
      defaultA <= 1'b0;
    end else begin
      if (stb.vbusSet)   vbusOn   <= 1'b1;
      if (stb.vbusClr)   vbusOn   <= 1'b0;
      if (stb.hostSet)   hostEn   <= 1'b1;
      if (stb.hostClr)   hostEn   <= 1'b0;
      if (stb.periphSet) periphEn <= 1'b1;
      if (stb.periphClr) periphEn <= 1'b0;
      if (stb.defASet)   defaultA <= 1'b1;
      if (stb.defAClr)   defaultA <= 1'b0;
    end
  end

  // request latches and the edge-set connected flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busReq   <= 1'b0;
      clrErr   <= 1'b0;
      bConn    <= 1'b0;
      connPrev <= 1'b0;
    end else begin
      connPrev <= connS;
      if (stb.reqClr || dropS) busReq <= 1'b0;
      else if (reqS)           busReq <= 1'b1;
      if (stb.errClr)            clrErr <= 1'b0;
      else if (clrS && defaultA) clrErr <= 1'b1;
      if (stb.connClr || !connS)  bConn <= 1'b0;
      else if (connS && !connPrev) bConn <= 1'b1;
    end
  end

  // connect-wait timer, counts ticks only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerRun <= 1'b0;
      timedOut <= 1'b0;
      tickCnt  <= '0;
    end else if (stb.timerStart) begin
      timerRun <= 1'b1;
      timedOut <= 1'b0;
      tickCnt  <= '0;
    end else if (stb.timerStop) begin
      timerRun <= 1'b0;
      timedOut <= 1'b0;
      tickCnt  <= '0;
    end else if (timerRun && tickS && !timedOut) begin
      if (tickCnt == LAST_CNT) timedOut <= 1'b1;
      else                     tickCnt  <= tickCnt + 1'b1;
    end
  end

  assert_expiry_needs_run_R6: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |-> timerRun);

  assert_req_dropped_R11: assert property (@(posedge clk) disable iff (!rstN)
    dropS |=> !busReq);

endmodule

// File: rtl/otg_role_ctrl.sv
module otg_role_ctrl
  import otg_role_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 2000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       idPin,
  input  logic       bSessValid,
  input  logic       aVbusValid,
  input  logic       aSessValid,
  input  logic       connDetect,
  input  logic       srpDetect,
  input  logic       busDrop,
  input  logic       busReqPulse,
  input  logic       clrErrPulse,
  input  logic       tick10ms,
  output logic       vbusOn,
  output logic       hostEn,
  output logic       periphEn,
  output logic       defaultA,
  output logic [3:0] roleState
);

  localparam int SIN_W = $bits(syncIn_t);
  localparam logic [SIN_W-1:0] SYNC_RST = {1'b1, {(SIN_W-1){1'b0}}};

  logic [SIN_W-1:0] rawIn;
  logic [SIN_W-1:0] syncVec;
  syncIn_t          sIn;
  strobe_t          stb;
  roleState_e       state;
  logic             busReq, clrErr, bConn, timedOut;

  assign rawIn = {idPin, bSessValid, aVbusValid, aSessValid, connDetect,
                  srpDetect, busDrop, busReqPulse, clrErrPulse, tick10ms};

  otg_role_sync #(.WIDTH(SIN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncVec)
  );

  assign sIn = syncIn_t'(syncVec);

  otg_role_fsm fsm_i (
    .clk(clk), .rstN(rstN),
    .idS(sIn.idS), .bSessS(sIn.bSessS), .aVbusS(sIn.aVbusS), .aSessS(sIn.aSessS),
    .srpS(sIn.srpS), .dropS(sIn.dropS),
    .busReq(busReq), .clrErr(clrErr), .bConn(bConn), .timedOut(timedOut),
    .state(state), .stb(stb)
  );

  otg_role_dp #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .connS(sIn.connS), .dropS(sIn.dropS), .reqS(sIn.reqS), .clrS(sIn.clrS),
    .tickS(sIn.tickS),
    .vbusOn(vbusOn), .hostEn(hostEn), .periphEn(periphEn), .defaultA(defaultA),
    .busReq(busReq), .clrErr(clrErr), .bConn(bConn), .timedOut(timedOut)
  );

  assign roleState = state;

  assert_engines_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(hostEn && periphEn));

  assert_periph_tracks_R2: assert property (@(posedge clk) disable iff (!rstN)
    periphEn == (state == ST_B_PERIPH));

  assert_vbus_off_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_UNDEF, ST_B_IDLE, ST_B_PERIPH, ST_A_IDLE}) |-> !vbusOn);

endmodule

// File: tb/otg_role_ctrl_tb.sv
module otg_role_ctrl_tb_top;

  localparam int TO_TICKS = 24;
  localparam int SETTLE   = 10;
  localparam int NVEC     = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idPin = 1'b1, bSessValid = 1'b0, aVbusValid = 1'b0, aSessValid = 1'b0;
  logic connDetect = 1'b0, srpDetect = 1'b0, busDrop = 1'b0;
  logic busReqPulse = 1'b0, clrErrPulse = 1'b0, tick10ms = 1'b0;
  logic vbusOn, hostEn, periphEn, defaultA;
  logic [3:0] roleState;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  otg_role_ctrl #(.TIMEOUT_TICKS(TO_TICKS)) dut_i (
    .clk(clk), .rstN(rstN), .idPin(idPin), .bSessValid(bSessValid),
    .aVbusValid(aVbusValid), .aSessValid(aSessValid), .connDetect(connDetect),
    .srpDetect(srpDetect), .busDrop(busDrop), .busReqPulse(busReqPulse),
    .clrErrPulse(clrErrPulse), .tick10ms(tick10ms),
    .vbusOn(vbusOn), .hostEn(hostEn), .periphEn(periphEn), .defaultA(defaultA),
    .roleState(roleState)
  );

  // inputs {id,bSess,aVbus,aSess,conn,srp,drop,req,clr}, state, {vbus,host,periph,defA}, tag
  localparam logic [20:0] VEC [NVEC] = '{
    {9'b110000000, 4'd3,  4'b0010, 4'd2},   // R2 B-session valid
    {9'b100000000, 4'd1,  4'b0000, 4'd2},   // R2 B-session lost
    {9'b110000000, 4'd3,  4'b0010, 4'd2},   // R2
    {9'b010000000, 4'd6,  4'b0001, 4'd2},   // R2 ID low leaves b_peripheral
    {9'b000001100, 4'd6,  4'b0001, 4'd3},   // R3 bus-drop blocks SRP
    {9'b000000110, 4'd6,  4'b0001, 4'd11},  // R11 request under drop
    {9'b000000000, 4'd6,  4'b0001, 4'd11},  // R11 request not latched
    {9'b000001000, 4'd7,  4'b1001, 4'd3},   // R3 SRP raises VBUS
    {9'b001000000, 4'd8,  4'b1101, 4'd4},   // R4 VBUS valid
    {9'b001010000, 4'd9,  4'b1101, 4'd5},   // R5 connect
    {9'b001000000, 4'd8,  4'b1101, 4'd7},   // R7 disconnect
    {9'b001010000, 4'd9,  4'b1101, 4'd7},   // R7
    {9'b000010000, 4'd13, 4'b1101, 4'd7},   // R7 VBUS lost in host
    {9'b000010100, 4'd12, 4'b0101, 4'd9},   // R9 drop clears error
    {9'b000110000, 4'd6,  4'b0001, 4'd8},   // R8 flag cleared, conn still high
    {9'b001110010, 4'd8,  4'b1101, 4'd11},  // R11 request latched; R8 no new edge
    {9'b000110100, 4'd6,  4'b0001, 4'd5},   // R5 drop outranks VBUS loss
    {9'b000000000, 4'd6,  4'b0001, 4'd11},  // R11 request cleared
    {9'b001001000, 4'd8,  4'b1101, 4'd4},   // R4
    {9'b000000000, 4'd13, 4'b1101, 4'd5},   // R5 VBUS loss in wait-connect
    {9'b000000000, 4'd13, 4'b1101, 4'd9},   // R9 error holds
    {9'b000000001, 4'd12, 4'b0101, 4'd9},   // R9 clear-error
    {9'b000100000, 4'd6,  4'b0001, 4'd10},  // R10 host off on a_idle from vfall
    {9'b001001000, 4'd8,  4'b1101, 4'd4},   // R4
    {9'b000000000, 4'd13, 4'b1101, 4'd9},   // R9 old clear-error not reused
    {9'b100000000, 4'd1,  4'b0000, 4'd10}   // R10 back to B-side, default-A clear
  };

  task automatic checkOut(input string tag, input logic [7:0] expv);
    logic [7:0] got;
    got = {roleState, vbusOn, hostEn, periphEn, defaultA};
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s: got state=%0d vbus/host/periph/defA=%b, expected state=%0d %b",
               tag, got[7:4], got[3:0], expv[7:4], expv[3:0]);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 in reset", 8'h00);
    rstN = 1'b1;
    repeat (SETTLE) @(negedge clk);
    checkOut("R1 after reset", {4'd1, 4'b0000});

    for (int i = 0; i < NVEC; i++) begin
      logic [20:0] v;
      v = VEC[i];
      {idPin, bSessValid, aVbusValid, aSessValid, connDetect, srpDetect, busDrop} = v[20:14];
      busReqPulse = v[13];
      clrErrPulse = v[12];
      @(negedge clk);
      busReqPulse = 1'b0;
      clrErrPulse = 1'b0;
      repeat (SETTLE) @(negedge clk);
      checkOut($sformatf("R%0d row %0d", v[3:0], i), v[11:4]);
    end

    // R6: wait-connect without ticks never expires
    {idPin, bSessValid, aVbusValid, aSessValid, connDetect, srpDetect, busDrop} = 7'b0010010;
    repeat (SETTLE) @(negedge clk);
    srpDetect = 1'b0;
    repeat (4 * TO_TICKS) @(negedge clk);
    checkOut("R6 no ticks", {4'd8, 4'b1101});

    // R6: ticks every cycle, expiry near TO_TICKS
    tick10ms = 1'b1;
    repeat (TO_TICKS - 4) @(negedge clk);
    checkOut("R6 before expiry", {4'd8, 4'b1101});
    repeat (10) @(negedge clk);
    checkOut("R6 expired to vfall", {4'd12, 4'b0101});
    tick10ms = 1'b0;

    // R1: reset mid-session
    rstN = 1'b0;
    @(negedge clk);
    checkOut("R1 reset mid-session", 8'h00);
    idPin = 1'b1;
    aVbusValid = 1'b0;
    rstN = 1'b1;
    repeat (SETTLE) @(negedge clk);
    checkOut("R1 restart to b_idle", {4'd1, 4'b0000});

    finish_run();
  end

endmodule